// File: doc/BRIEF.md
# Mirrored Memory-Map Address Decoder

This block turns a 24-bit processor address and a request strobe into a one-hot region select, a local offset for the selected memory, and a flag for accesses that land in no region. Four regions are decoded: a boot ROM, a low RAM placed directly above the ROM window, a 4 KB internal RAM window and a 4 KB peripheral I/O window near the top of the address space.

The physical memories behind some windows are smaller than the windows themselves, so the decoder folds the address. The ROM (a power-of-two size) repeats through the whole first megabyte. Each 4 KB high window is backed by only 1 KB, so it appears four times within the window. The folded offset is what the selected memory receives. Low RAM is not folded; its offset is the distance from its base.

Results are registered: select, offset and error reflect the address and strobe presented one clock earlier.

Top module: `mirror_map_decoder`

## Requirements
- R1: While rst_n is low, and on the first edge after it, sel, ofs and err are all zero.
- R2: A request with address 0x000000..0x0FFFFF asserts sel = 4'b0001 (bit 0, ROM) and ofs = address modulo ROM_BYTES (default 0x40000), err low.
- R3: A request with address 0x100000 up to LOW_END-1 (default LOW_END = 0x200000) asserts sel = 4'b0010 (bit 1, low RAM) and ofs = address - 0x100000, err low.
- R4: A request with address 0xFFE000..0xFFEFFF asserts sel = 4'b0100 (bit 2, internal RAM) and ofs = address bits 9:0 zero-extended, err low.
- R5: A request with address 0xFFF000..0xFFFFFF asserts sel = 4'b1000 (bit 3, peripheral I/O) and ofs = address bits 9:0 zero-extended, err low.
- R6: A request with an address in no window sets err = 1 with sel = 0 and ofs = 0.
- R7: With req low, sel = 0, err = 0 and ofs = 0 regardless of address.
- R8: Outputs change exactly one clock after the inputs; for a request exactly one of (some sel bit, err) is high, and sel never has more than one bit set.
- R9: Window edges are exact: LOW_END itself and 0xFFDFFF are unmapped, 0x0FFFFF is ROM and 0x100000 is low RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request strobe |
| addr | input | ADDR_W (24) | Byte address |
| sel | output | 4 | One-hot region select: 0 ROM, 1 low RAM, 2 internal RAM, 3 I/O |
| ofs | output | ADDR_W (24) | Folded local offset into the selected memory |
| err | output | 1 | Request hit no mapped window |

## Verification
Every output of this decoder is due on the first rising edge after the address and strobe are presented, since one register stage sits between the inputs and sel, ofs and err. The bench drives inputs on the falling edge, waits for the next rising edge and samples a nanosecond later, so each check sees exactly the decode of the stimulus just applied. One latency check samples before that edge to confirm the previous decode is still held, and the boundary addresses of each window are applied back to back so a stale value would be caught.

// File: rtl/mm_decode_pkg.sv
package mm_decode_pkg;

    localparam int unsigned REGION_N = 4;

    localparam int unsigned RG_ROM  = 0;
    localparam int unsigned RG_LRAM = 1;
    localparam int unsigned RG_IRAM = 2;
    localparam int unsigned RG_PIO  = 3;

    localparam int unsigned DEC_ADDR_W = 24;

    typedef struct packed {
        logic [REGION_N-1:0]   sel;
        logic [DEC_ADDR_W-1:0] ofs;
        logic                  err;
    } dec_t;

endpackage

// File: rtl/mm_window.sv
module mm_window #(
    parameter int unsigned     ADDR_W = 24,
    parameter longint unsigned BASE   = 0,
    parameter longint unsigned LIMIT  = 64'h100000,
    parameter longint unsigned FOLD   = 64'h40000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] ofs
);
    localparam logic [ADDR_W:0]   BASE_V = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0]   LIM_V  = (ADDR_W+1)'(LIMIT);
    localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'(FOLD - 1);

    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] rel;

    always_comb begin
        addr_x = {1'b0, addr};
        hit    = (addr_x >= BASE_V) && (addr_x < LIM_V);
        rel    = addr - BASE_V[ADDR_W-1:0];
        ofs    = rel & MASK_V;
    end
endmodule

// File: rtl/mm_onehot_mux.sv
module mm_onehot_mux #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 24
) (
    input  logic [N-1:0]        hot,
    input  logic [N-1:0][W-1:0] data,
    output logic [W-1:0]        out
);
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            if (hot[i]) out = out | data[i];
        end
    end
endmodule

// File: rtl/mirror_map_decoder.sv
module mirror_map_decoder
    import mm_decode_pkg::*;
#(
    parameter int unsigned     ADDR_W    = DEC_ADDR_W,
    parameter longint unsigned ROM_SPAN  = 64'h100000,
    parameter longint unsigned ROM_BYTES = 64'h40000,
    parameter longint unsigned LOW_END   = 64'h200000,
    parameter longint unsigned IRAM_BASE = 64'hFFE000,
    parameter longint unsigned PIO_BASE  = 64'hFFF000,
    parameter longint unsigned WIN_SPAN  = 64'h1000,
    parameter longint unsigned WIN_BYTES = 64'h400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    output logic [REGION_N-1:0] sel,
    output logic [ADDR_W-1:0]   ofs,
    output logic                err
);
    localparam longint unsigned FULL_FOLD = 64'd1 << ADDR_W;

    localparam longint unsigned W_BASE [REGION_N] =
        '{0, ROM_SPAN, IRAM_BASE, PIO_BASE};
    localparam longint unsigned W_LIM  [REGION_N] =
        '{ROM_SPAN, LOW_END, IRAM_BASE + WIN_SPAN, PIO_BASE + WIN_SPAN};
    localparam longint unsigned W_FOLD [REGION_N] =
        '{ROM_BYTES, FULL_FOLD, WIN_BYTES, WIN_BYTES};

    typedef struct packed {
        logic [REGION_N-1:0] sel;
        logic [ADDR_W-1:0]   ofs;
        logic                err;
    } state_t;

    logic [REGION_N-1:0]             hit;
    logic [REGION_N-1:0][ADDR_W-1:0] win_ofs;
    logic [ADDR_W-1:0]               mux_ofs;
    state_t                          st_d, st_q;

    for (genvar g = 0; g < REGION_N; g++) begin : g_win
        mm_window #(
            .ADDR_W (ADDR_W),
            .BASE   (W_BASE[g]),
            .LIMIT  (W_LIM[g]),
            .FOLD   (W_FOLD[g])
        ) u_win (
            .addr (addr),
            .hit  (hit[g]),
            .ofs  (win_ofs[g])
        );
    end

    mm_onehot_mux #(
        .N (REGION_N),
        .W (ADDR_W)
    ) u_mux (
        .hot  (hit),
        .data (win_ofs),
        .out  (mux_ofs)
    );

    always_comb begin
        st_d = '0;
        if (req) begin
            st_d.sel = hit;
            st_d.ofs = mux_ofs;
            st_d.err = (hit == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;
    assign ofs = st_q.ofs;
    assign err = st_q.err;
endmodule

// File: rtl/mirror_map_decoder_chk.sv
module mirror_map_decoder_chk #(
    parameter int unsigned     ADDR_W    = 24,
    parameter longint unsigned IRAM_BASE = 64'hFFE000,
    parameter longint unsigned PIO_BASE  = 64'hFFF000,
    parameter longint unsigned WIN_SPAN  = 64'h1000,
    parameter longint unsigned WIN_BYTES = 64'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        sel,
    input logic [ADDR_W-1:0] ofs,
    input logic              err
);
    localparam logic [ADDR_W-1:0] PIO_LO  = ADDR_W'(PIO_BASE);
    localparam logic [ADDR_W:0]   PIO_HI  = (ADDR_W+1)'(PIO_BASE + WIN_SPAN);
    localparam logic [ADDR_W-1:0] IRAM_LO = ADDR_W'(IRAM_BASE);
    localparam logic [ADDR_W-1:0] IRAM_HI = ADDR_W'(IRAM_BASE + WIN_SPAN);
    localparam logic [ADDR_W-1:0] LOC_M   = ADDR_W'(WIN_BYTES - 1);

    // R8: never more than one region selected
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R8: a request produces either a select or an error, not both
    assert_req_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ((sel != 4'b0) != err));

    // R6: error excludes any select
    assert_err_no_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sel == 4'b0 && ofs == '0));

    // R7: idle strobe yields quiet outputs
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (sel == 4'b0 && !err && ofs == '0));

    // R5: I/O window selected with folded offset
    assert_pio_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr >= PIO_LO && {1'b0, addr} < PIO_HI)
        |=> (sel == 4'b1000 && ofs == ($past(addr) & LOC_M)));

    // R4: internal RAM window selected with folded offset
    assert_iram_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr >= IRAM_LO && addr < IRAM_HI)
        |=> (sel == 4'b0100 && ofs == ($past(addr) & LOC_M)));
endmodule

bind mirror_map_decoder mirror_map_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .IRAM_BASE (IRAM_BASE),
    .PIO_BASE  (PIO_BASE),
    .WIN_SPAN  (WIN_SPAN),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .addr  (addr),
    .sel   (sel),
    .ofs   (ofs),
    .err   (err)
);

// File: tb/mirror_map_decoder_bench.sv
`timescale 1ns/1ps
module mirror_map_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic [3:0]  sel;
    logic [23:0] ofs;
    logic        err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mirror_map_decoder u_mirror_map_decoder (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .addr  (addr),
        .sel   (sel),
        .ofs   (ofs),
        .err   (err)
    );

    task automatic check(string tag, logic [3:0] es, logic [23:0] eo, logic ee);
        n_chk++;
        if (sel !== es || ofs !== eo || err !== ee) begin
            n_err++;
            $display("FAIL %s: got sel=%b ofs=%h err=%b, expected sel=%b ofs=%h err=%b",
                     tag, sel, ofs, err, es, eo, ee);
        end
    endtask

    // Drive on falling edge, sample 1 ns after the next rising edge.
    task automatic apply(logic r, logic [23:0] a);
        @(negedge clk);
        req  = r;
        addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req   = 1'b1;
        addr  = 24'h000010;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 4'b0, 24'h0, 1'b0);
        @(negedge clk);
        req   = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 first edge", 4'b0, 24'h0, 1'b0);
    endtask

    task automatic t_rom();
        apply(1'b1, 24'h000000); check("R2 rom base", 4'b0001, 24'h000000, 1'b0);
        apply(1'b1, 24'h012345); check("R2 rom inside", 4'b0001, 24'h012345, 1'b0);
        apply(1'b1, 24'h040000); check("R2 rom mirror1", 4'b0001, 24'h000000, 1'b0);
        apply(1'b1, 24'h0ABCDE); check("R2 rom mirror2", 4'b0001, 24'h02BCDE, 1'b0);
        apply(1'b1, 24'h0FFFFF); check("R2 R9 rom top", 4'b0001, 24'h03FFFF, 1'b0);
    endtask

    task automatic t_lram();
        apply(1'b1, 24'h100000); check("R3 R9 lram base", 4'b0010, 24'h000000, 1'b0);
        apply(1'b1, 24'h154321); check("R3 lram inside", 4'b0010, 24'h054321, 1'b0);
        apply(1'b1, 24'h1FFFFF); check("R3 lram top", 4'b0010, 24'h0FFFFF, 1'b0);
        apply(1'b1, 24'h200000); check("R9 lram end unmapped", 4'b0000, 24'h0, 1'b1);
    endtask

    task automatic t_iram();
        apply(1'b1, 24'hFFE000); check("R4 iram base", 4'b0100, 24'h000000, 1'b0);
        apply(1'b1, 24'hFFE7FF); check("R4 iram mirror", 4'b0100, 24'h0003FF, 1'b0);
        apply(1'b1, 24'hFFEC05); check("R4 iram mirror3", 4'b0100, 24'h000005, 1'b0);
        apply(1'b1, 24'hFFDFFF); check("R9 below iram", 4'b0000, 24'h0, 1'b1);
    endtask

    task automatic t_pio();
        apply(1'b1, 24'hFFF400); check("R5 pio mirror1", 4'b1000, 24'h000000, 1'b0);
        apply(1'b1, 24'hFFF2AB); check("R5 pio inside", 4'b1000, 24'h0002AB, 1'b0);
        apply(1'b1, 24'hFFFFFF); check("R5 pio top", 4'b1000, 24'h0003FF, 1'b0);
    endtask

    task automatic t_hole();
        apply(1'b1, 24'h800000); check("R6 hole mid", 4'b0000, 24'h0, 1'b1);
        apply(1'b1, 24'hFFD000); check("R6 hole high", 4'b0000, 24'h0, 1'b1);
    endtask

    task automatic t_idle();
        apply(1'b0, 24'hFFF123); check("R7 idle pio addr", 4'b0000, 24'h0, 1'b0);
        apply(1'b0, 24'h900000); check("R7 idle hole addr", 4'b0000, 24'h0, 1'b0);
    endtask

    task automatic t_latency();
        apply(1'b1, 24'h000020); check("R8 setup rom", 4'b0001, 24'h000020, 1'b0);
        @(negedge clk);
        req  = 1'b1;
        addr = 24'hFFE010;
        #1;
        check("R8 held before edge", 4'b0001, 24'h000020, 1'b0);
        @(posedge clk);
        #1;
        check("R8 after edge", 4'b0100, 24'h000010, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rom();
        t_lram();
        t_iram();
        t_pio();
        t_hole();
        t_idle();
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule